// File: doc/BRIEF.md
# Shared Integer and Floating-Point Register File

This block is the architectural register file of a 32-bit core whose floating-point unit has no registers of its own. Every scalar floating-point operand and result lives in the 32 general-purpose registers. Integer logic reaches them through ordinary 32-bit read and write ports. Floating-point logic reaches them through ports that carry half (16-bit), single (32-bit) or double (64-bit) values.

A double always occupies an aligned pair of registers. The even register holds the low word and the next register holds the high word, whatever the byte order of the core. Pair specifiers are validated on both read and write. Narrow results are widened with ones when written back. Source operands are handed over exactly as stored, with no check on how they were boxed.

Register x0 stays zero throughout. A floating-point write aimed at it still reports acceptance, so the exception-flag logic elsewhere behaves the same as for any other target. Reads are combinational. Writes land on the rising clock edge. Reset is synchronous and active high.

Top module: `shared_xf_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero.
- R2: Integer reads are combinational. Integer writes take effect at the rising edge. Register x0 always reads zero, and integer writes to it are ignored.
- R3: A double read (width code 2) at an even register n returns x(n+1) in bits [63:32] and x(n) in bits [31:0]. The pair order never changes.
- R4: A double write (width code 2) at an even register n stores bits [31:0] into x(n) and bits [63:32] into x(n+1) at the next rising edge.
- R5: A double access with an odd register number raises the illegal flag of that port. For a read, the data is zero. For a write, no register changes and `fwr_accept` stays low.
- R6: A double read of the pair at x0 returns all zeros, even when x1 holds a nonzero value.
- R7: A double write to the pair at x0 is discarded as a whole, so x1 keeps its value. The write still reports accepted.
- R8: A single write (width code 1) stores bits [31:0] into exactly one register and leaves its pair neighbour untouched.
- R9: A half write (width code 0) stores {16'hFFFF, data[15:0]} into the target register.
- R10: Half and single floating-point reads return the raw 32 register bits in [31:0], with zeros above. No boxing check is applied.
- R11: A legal floating-point write targeting x0 stores nothing, yet `fwr_accept` is high in that cycle.
- R12: When an integer write and a floating-point write hit the same register in one cycle, the floating-point value is stored. An integer write to a different register in the same cycle still lands.
- R13: Width code 3 is reserved. A write or read using it raises the illegal flag, and a write using it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ird_a_addr | input | 5 | Integer read port A register number |
| ird_a_data | output | 32 | Integer read port A data |
| ird_b_addr | input | 5 | Integer read port B register number |
| ird_b_data | output | 32 | Integer read port B data |
| iwr_en | input | 1 | Integer write enable |
| iwr_addr | input | 5 | Integer write register number |
| iwr_data | input | 32 | Integer write data |
| frd_a_addr | input | 5 | FP read port A register number |
| frd_a_width | input | 2 | FP read port A width code (0 half, 1 single, 2 double, 3 reserved) |
| frd_a_data | output | 64 | FP read port A operand |
| frd_a_illegal | output | 1 | FP read port A illegal specifier |
| frd_b_addr | input | 5 | FP read port B register number |
| frd_b_width | input | 2 | FP read port B width code |
| frd_b_data | output | 64 | FP read port B operand |
| frd_b_illegal | output | 1 | FP read port B illegal specifier |
| fwr_en | input | 1 | FP write enable |
| fwr_addr | input | 5 | FP write register number |
| fwr_width | input | 2 | FP write width code |
| fwr_data | input | 64 | FP result, low bits used for narrow widths |
| fwr_accept | output | 1 | FP write taken as legal (also for x0) |
| fwr_illegal | output | 1 | FP write rejected for bad specifier or width |

## Verification
The embedded properties check several behaviours on every cycle:
- a rejected double write leaves its target register unchanged;
- a single write leaves the pair neighbour alone;
- a half write lands with ones above;
- a discarded write to the x0 pair preserves x1;
- the floating-point value wins a same-register conflict;
- a double read agrees with the integer view of its low word.

Some behaviours can only be shown by the bench scenarios:
- reset clearing the whole file;
- correct word order across many pairs;
- raw return of unboxed sources;
- acceptance reported for x0 targets;
- handling of the reserved width code.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
   typedef enum logic [1:0] {
      FPW_HALF = 2'd0,
      FPW_SNGL = 2'd1,
      FPW_DBL  = 2'd2,
      FPW_RSV  = 2'd3
   } fp_width_e;
endpackage

// File: rtl/fprf_storage.sv
module fprf_storage #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            int_we,
   input  logic [AW-1:0]   int_addr,
   input  logic [XLEN-1:0] int_data,
   input  logic            lo_we,
   input  logic [AW-1:0]   lo_addr,
   input  logic [XLEN-1:0] lo_data,
   input  logic            hi_we,
   input  logic [AW-1:0]   hi_addr,
   input  logic [XLEN-1:0] hi_data,
   output logic [XLEN-1:0] rf_q [NREGS]
);
   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign rf_q[i] = '0;
      end else begin : g_live
         logic [XLEN-1:0] q;
         // FP halves take precedence over the integer port
         always_ff @(posedge clk) begin
            if (rst)                                 q <= '0;
            else if (lo_we && lo_addr == AW'(i))     q <= lo_data;
            else if (hi_we && hi_addr == AW'(i))     q <= hi_data;
            else if (int_we && int_addr == AW'(i))   q <= int_data;
         end
         assign rf_q[i] = q;
      end
   end
endmodule

// File: rtl/fprf_fp_rd.sv
module fprf_fp_rd
   import fprf_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS),
   localparam int FLEN = 2 * XLEN
) (
   input  logic [AW-1:0]   addr,
   input  logic [1:0]      width,
   input  logic [XLEN-1:0] rf_q [NREGS],
   output logic [FLEN-1:0] data,
   output logic            illegal
);
   logic [AW-1:0] odd_addr;
   assign odd_addr = {addr[AW-1:1], 1'b1};

   always_comb begin
      data    = '0;
      illegal = 1'b0;
      case (fp_width_e'(width))
         FPW_HALF, FPW_SNGL: data = {{XLEN{1'b0}}, rf_q[addr]};
         FPW_DBL: begin
            if (addr[0])            illegal = 1'b1;
            else if (addr == '0)    data = '0;
            else                    data = {rf_q[odd_addr], rf_q[addr]};
         end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/fprf_fp_wb.sv
module fprf_fp_wb
   import fprf_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int HLEN  = 16,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS),
   localparam int FLEN = 2 * XLEN
) (
   input  logic            en,
   input  logic [AW-1:0]   addr,
   input  logic [1:0]      width,
   input  logic [FLEN-1:0] data,
   output logic            accept,
   output logic            illegal,
   output logic            lo_we,
   output logic [AW-1:0]   lo_addr,
   output logic [XLEN-1:0] lo_data,
   output logic            hi_we,
   output logic [AW-1:0]   hi_addr,
   output logic [XLEN-1:0] hi_data
);
   logic bad, dbl, nonzero;

   always_comb begin
      bad     = 1'b0;
      dbl     = 1'b0;
      lo_data = data[XLEN-1:0];
      hi_data = data[FLEN-1:XLEN];
      case (fp_width_e'(width))
         FPW_HALF: lo_data = {{(XLEN-HLEN){1'b1}}, data[HLEN-1:0]};
         FPW_SNGL: lo_data = data[XLEN-1:0];
         FPW_DBL: begin
            dbl = 1'b1;
            bad = addr[0];
         end
         default: bad = 1'b1;
      endcase
   end

   assign nonzero = (addr != '0);
   assign accept  = en & ~bad;
   assign illegal = en & bad;
   assign lo_addr = addr;
   assign hi_addr = {addr[AW-1:1], 1'b1};
   assign lo_we   = accept & nonzero;
   assign hi_we   = accept & nonzero & dbl;
endmodule

// File: rtl/shared_xf_regfile.sv
module shared_xf_regfile
   import fprf_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int HLEN  = 16,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS),
   localparam int FLEN = 2 * XLEN
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [AW-1:0]   ird_a_addr,
   output logic [XLEN-1:0] ird_a_data,
   input  logic [AW-1:0]   ird_b_addr,
   output logic [XLEN-1:0] ird_b_data,
   input  logic            iwr_en,
   input  logic [AW-1:0]   iwr_addr,
   input  logic [XLEN-1:0] iwr_data,
   input  logic [AW-1:0]   frd_a_addr,
   input  logic [1:0]      frd_a_width,
   output logic [FLEN-1:0] frd_a_data,
   output logic            frd_a_illegal,
   input  logic [AW-1:0]   frd_b_addr,
   input  logic [1:0]      frd_b_width,
   output logic [FLEN-1:0] frd_b_data,
   output logic            frd_b_illegal,
   input  logic            fwr_en,
   input  logic [AW-1:0]   fwr_addr,
   input  logic [1:0]      fwr_width,
   input  logic [FLEN-1:0] fwr_data,
   output logic            fwr_accept,
   output logic            fwr_illegal
);
   // elaboration-time parameter checks
   if (HLEN >= XLEN)              $error("HLEN must be narrower than XLEN");
   if (NREGS < 2)                 $error("NREGS must hold at least one pair");
   if ((1 << AW) != NREGS)        $error("NREGS must be a power of two");

   logic [XLEN-1:0] rf_q [NREGS];
   logic            lo_we, hi_we;
   logic [AW-1:0]   lo_addr, hi_addr;
   logic [XLEN-1:0] lo_data, hi_data;

   fprf_fp_wb #(.XLEN(XLEN), .HLEN(HLEN), .NREGS(NREGS)) u_wb (
      .en(fwr_en), .addr(fwr_addr), .width(fwr_width), .data(fwr_data),
      .accept(fwr_accept), .illegal(fwr_illegal),
      .lo_we(lo_we), .lo_addr(lo_addr), .lo_data(lo_data),
      .hi_we(hi_we), .hi_addr(hi_addr), .hi_data(hi_data)
   );

   fprf_storage #(.XLEN(XLEN), .NREGS(NREGS)) u_store (
      .clk(clk), .rst(rst),
      .int_we(iwr_en), .int_addr(iwr_addr), .int_data(iwr_data),
      .lo_we(lo_we), .lo_addr(lo_addr), .lo_data(lo_data),
      .hi_we(hi_we), .hi_addr(hi_addr), .hi_data(hi_data),
      .rf_q(rf_q)
   );

   assign ird_a_data = rf_q[ird_a_addr];
   assign ird_b_data = rf_q[ird_b_addr];

   fprf_fp_rd #(.XLEN(XLEN), .NREGS(NREGS)) u_rd_a (
      .addr(frd_a_addr), .width(frd_a_width), .rf_q(rf_q),
      .data(frd_a_data), .illegal(frd_a_illegal)
   );

   fprf_fp_rd #(.XLEN(XLEN), .NREGS(NREGS)) u_rd_b (
      .addr(frd_b_addr), .width(frd_b_width), .rf_q(rf_q),
      .data(frd_b_data), .illegal(frd_b_illegal)
   );

   // R5
   odd_pair_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (fwr_en && fwr_width == 2'd2 && fwr_addr[0] && !iwr_en)
      |=> rf_q[$past(fwr_addr)] == $past(rf_q[fwr_addr]));

   // R8
   single_neighbour_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (fwr_en && fwr_width == 2'd1 && !iwr_en)
      |=> rf_q[$past(fwr_addr) ^ AW'(1)] == $past(rf_q[fwr_addr ^ AW'(1)]));

   // R9
   half_boxed_chk: assert property (@(posedge clk) disable iff (rst)
      (fwr_en && fwr_width == 2'd0 && fwr_addr != '0)
      |=> rf_q[$past(fwr_addr)] == {{(XLEN-HLEN){1'b1}}, $past(fwr_data[HLEN-1:0])});

   // R7
   zero_pair_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (fwr_en && fwr_width == 2'd2 && fwr_addr == '0 && !iwr_en)
      |=> rf_q[1] == $past(rf_q[1]));

   // R12
   fp_wins_conflict_chk: assert property (@(posedge clk) disable iff (rst)
      (fwr_en && fwr_width == 2'd1 && iwr_en && iwr_addr == fwr_addr && fwr_addr != '0)
      |=> rf_q[$past(fwr_addr)] == $past(fwr_data[XLEN-1:0]));

   // R3
   pair_low_word_chk: assert property (@(posedge clk) disable iff (rst)
      (frd_a_width == 2'd2 && !frd_a_addr[0] && ird_a_addr == frd_a_addr)
      |-> frd_a_data[XLEN-1:0] == ird_a_data);

   // R6
   zero_pair_read_chk: assert property (@(posedge clk) disable iff (rst)
      (frd_b_width == 2'd2 && frd_b_addr == '0) |-> frd_b_data == '0);
endmodule

// File: tb/sim_shared_xf_regfile.sv
module sim_shared_xf_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  ird_a_addr = '0, ird_b_addr = '0, iwr_addr = '0;
   logic [31:0] ird_a_data, ird_b_data, iwr_data = '0;
   logic        iwr_en = 1'b0;
   logic [4:0]  frd_a_addr = '0, frd_b_addr = '0, fwr_addr = '0;
   logic [1:0]  frd_a_width = '0, frd_b_width = '0, fwr_width = '0;
   logic [63:0] frd_a_data, frd_b_data, fwr_data = '0;
   logic        frd_a_illegal, frd_b_illegal, fwr_en = 1'b0;
   logic        fwr_accept, fwr_illegal;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   shared_xf_regfile u0 (.*);

   typedef struct packed {
      logic [3:0]  req;
      logic        ie;  logic [4:0] ia; logic [31:0] id;
      logic        fe;  logic [4:0] fa; logic [1:0]  fw; logic [63:0] fd;
      logic        acc; logic       ill;
      logic [4:0]  ca;  logic [31:0] ea;
      logic [4:0]  cb;  logic [31:0] eb;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R2 integer write
      '{4'd2, 1'b1, 5'd5, 32'h1234_5678, 1'b0, 5'd0, 2'd0, 64'h0, 1'b0, 1'b0, 5'd5, 32'h1234_5678, 5'd4, 32'h0},
      // R4 double write at x6
      '{4'd4, 1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 2'd2, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b0, 5'd6, 32'hCCCC_DDDD, 5'd7, 32'hAAAA_BBBB},
      // R4 double write at x8
      '{4'd4, 1'b0, 5'd0, 32'h0, 1'b1, 5'd8, 2'd2, 64'h9999_8888_7777_6666, 1'b1, 1'b0, 5'd8, 32'h7777_6666, 5'd9, 32'h9999_8888},
      // R8 single write leaves x9
      '{4'd8, 1'b0, 5'd0, 32'h0, 1'b1, 5'd8, 2'd1, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 5'd8, 32'h3333_4444, 5'd9, 32'h9999_8888},
      // R9 half write boxed
      '{4'd9, 1'b0, 5'd0, 32'h0, 1'b1, 5'd10, 2'd0, 64'h5555_6666_7777_ABCD, 1'b1, 1'b0, 5'd10, 32'hFFFF_ABCD, 5'd11, 32'h0},
      // R5 odd double write rejected
      '{4'd5, 1'b0, 5'd0, 32'h0, 1'b1, 5'd11, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 5'd11, 32'h0, 5'd10, 32'hFFFF_ABCD},
      // R2 load x1
      '{4'd2, 1'b1, 5'd1, 32'hDEAD_BEEF, 1'b0, 5'd0, 2'd0, 64'h0, 1'b0, 1'b0, 5'd1, 32'hDEAD_BEEF, 5'd0, 32'h0},
      // R7 x0 pair write dropped
      '{4'd7, 1'b0, 5'd0, 32'h0, 1'b1, 5'd0, 2'd2, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 5'd0, 32'h0, 5'd1, 32'hDEAD_BEEF},
      // R11 single write to x0 accepted, not stored
      '{4'd11, 1'b0, 5'd0, 32'h0, 1'b1, 5'd0, 2'd1, 64'h0000_0000_5A5A_5A5A, 1'b1, 1'b0, 5'd0, 32'h0, 5'd1, 32'hDEAD_BEEF},
      // R12 same-register conflict
      '{4'd12, 1'b1, 5'd12, 32'hCAFE_0000, 1'b1, 5'd12, 2'd1, 64'h0000_0000_1357_2468, 1'b1, 1'b0, 5'd12, 32'h1357_2468, 5'd13, 32'h0},
      // R12 different registers both land
      '{4'd12, 1'b1, 5'd13, 32'h0BAD_F00D, 1'b1, 5'd14, 2'd1, 64'h0000_0000_7777_7777, 1'b1, 1'b0, 5'd13, 32'h0BAD_F00D, 5'd14, 32'h7777_7777},
      // R13 reserved width
      '{4'd13, 1'b0, 5'd0, 32'h0, 1'b1, 5'd14, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 5'd14, 32'h7777_7777, 5'd15, 32'h0},
      // R2 integer write to x0 ignored
      '{4'd2, 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0, 5'd0, 2'd0, 64'h0, 1'b0, 1'b0, 5'd0, 32'h0, 5'd5, 32'h1234_5678},
      // R12 double write beats integer write to high half
      '{4'd12, 1'b1, 5'd3, 32'h0000_0055, 1'b1, 5'd2, 2'd2, 64'h3333_3333_2222_2222, 1'b1, 1'b0, 5'd2, 32'h2222_2222, 5'd3, 32'h3333_3333}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      @(negedge clk);
      iwr_en = v.ie; iwr_addr = v.ia; iwr_data = v.id;
      fwr_en = v.fe; fwr_addr = v.fa; fwr_width = v.fw; fwr_data = v.fd;
      ird_a_addr = v.ca; ird_b_addr = v.cb;
      #1;
      chk($sformatf("R%0d vec%0d accept", v.req, idx), 64'(fwr_accept), 64'(v.acc));
      chk($sformatf("R%0d vec%0d illegal", v.req, idx), 64'(fwr_illegal), 64'(v.ill));
      @(posedge clk);
      #1;
      iwr_en = 1'b0; fwr_en = 1'b0;
      #1;
      chk($sformatf("R%0d vec%0d port A", v.req, idx), 64'(ird_a_data), 64'(v.ea));
      chk($sformatf("R%0d vec%0d port B", v.req, idx), 64'(ird_b_data), 64'(v.eb));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 reset state of every register
      for (int r = 0; r < 32; r++) begin
         ird_a_addr = 5'(r);
         #1 chk($sformatf("R1 reset x%0d", r), 64'(ird_a_data), 64'h0);
      end
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      @(negedge clk);
      // R2 combinational read: new address, no clock edge
      ird_a_addr = 5'd13;
      #1 chk("R2 comb read", 64'(ird_a_data), 64'h0BAD_F00D);
      // R3 pair order
      frd_a_addr = 5'd6; frd_a_width = 2'd2;
      #1 chk("R3 double read x6", frd_a_data, 64'hAAAA_BBBB_CCCC_DDDD);
      chk("R3 illegal low", 64'(frd_a_illegal), 64'h0);
      // R6 x0 pair read with x1 nonzero
      frd_b_addr = 5'd0; frd_b_width = 2'd2;
      #1 chk("R6 x0 pair read", frd_b_data, 64'h0);
      // R5 odd double read
      frd_a_addr = 5'd7; frd_a_width = 2'd2;
      #1 chk("R5 odd read illegal", 64'(frd_a_illegal), 64'h1);
      chk("R5 odd read data", frd_a_data, 64'h0);
      // R10 raw narrow reads
      frd_a_addr = 5'd10; frd_a_width = 2'd0;
      #1 chk("R10 half read", frd_a_data, 64'h0000_0000_FFFF_ABCD);
      frd_b_addr = 5'd5; frd_b_width = 2'd1;
      #1 chk("R10 single read unboxed", frd_b_data, 64'h0000_0000_1234_5678);
      // R13 reserved width on read
      frd_b_width = 2'd3;
      #1 chk("R13 reserved read illegal", 64'(frd_b_illegal), 64'h1);

      // R1 reset again clears live contents
      rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      ird_a_addr = 5'd6; ird_b_addr = 5'd1;
      #1 chk("R1 reset x6", 64'(ird_a_data), 64'h0);
      chk("R1 reset x1", 64'(ird_b_data), 64'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end
endmodule